// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block models the command front end of a NOR-style flash device. It watches host write beats (valid, address, data) and recognises a six-write sector erase command. Once the command is recognised, it opens a timed acceptance window. During that window the host may queue more sectors with single sector-erase writes. When the window runs out, an erase phase starts. A cycle counter stands in for the erase itself, and the block returns to read mode when that count ends.

A foreign command written inside the window aborts the whole request. An erase-suspend write parks the operation, and the sector-erase code resumes it. A hardware reset ends everything at once. Three pins report the status: a ready/busy flag, a window-done flag and a suspended flag. A pending-sector bitmap shows which sectors are queued.

The write port has no back-pressure. Every beat with `wr_valid` high is consumed in the clock cycle in which it is sampled, and the block has no ready signal on that port. Sector index is taken from the top `$clog2(NUM_SECT)` address bits.

Top module: `erase_cmd_seq`

## Requirements
- R1: While reset is asserted and after it is released, `ready_o`=1, `win_done_o`=0, `susp_o`=0 and `pend_map_o`=0.
- R2: The command consists of six writes in read mode, in this order: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), then (sector address, 0x30). After the edge that samples the last write, `ready_o`=0, `win_done_o`=0 and the bit of that sector is set in `pend_map_o`.
- R3: A write whose address or data does not match the expected step returns the decoder to its first step. A later partial completion of the command then starts nothing, and `ready_o` stays 1 with `pend_map_o`=0.
- R4: Inside the window, a write with data 0x30 sets its sector bit and restarts the window. A write is accepted if it is sampled within WIN_CYC cycles of the previous accepted write.
- R5: `win_done_o` rises after the edge that comes WIN_CYC cycles after the last accepted window write with no write in between. At that point the erase phase begins.
- R6: Inside the window, a write whose data is neither 0x30 nor 0xB0 returns the block to read mode. After that edge `ready_o`=1, `win_done_o`=0 and `pend_map_o`=0.
- R7: Inside the window, a write with data 0xB0 ends the window and suspends the operation. Then `susp_o`=1, `win_done_o`=1 and `ready_o`=1, and `pend_map_o` is kept.
- R8: The erase phase lasts ERASE_CYC cycles. After the edge that ends it, `ready_o`=1, `win_done_o`=0 and `pend_map_o`=0.
- R9: During the erase phase, every write except 0xB0 is ignored, including a full six-write command. The bitmap, the busy flag and the erase timing stay as they were.
- R10: Writing 0xB0 during erase suspends it with its elapsed count held. Writing 0x30 while suspended resumes it. The cycles spent erasing before and after the suspension add up to ERASE_CYC. A suspension taken from the window resumes into a full ERASE_CYC erase.
- R11: Asserting reset during erase returns the block to the R1 state at once, without waiting for a clock edge.
- R12: While suspended, every write other than 0x30 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write beat valid; always consumed |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command code |
| ready_o | output | 1 | 1 = ready, 0 = busy (window or erase) |
| win_done_o | output | 1 | Acceptance window has ended (erasing or suspended) |
| susp_o | output | 1 | Operation is suspended |
| pend_map_o | output | NUM_SECT | Sectors queued for erase |

## Verification
Each output is decoded from registers with no further stage. The effect of a write sampled at one rising edge therefore shows up on the outputs right after that same edge. Window expiry and erase completion land exactly WIN_CYC and ERASE_CYC edges after the write or phase change that started them. The bench drives its inputs at the falling edge and steps its reference model after the rising edge. It compares all outputs at the next falling edge, so every comparison falls in the first cycle in which the result is due. The directed checks count idle edges to land on the last cycle before expiry or completion and on the first cycle after it.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [1:0] {
    PH_READ,
    PH_WINDOW,
    PH_ERASE,
    PH_SUSP
  } phase_e;

  typedef enum logic [2:0] {
    UL_IDLE,
    UL_A1,
    UL_B1,
    UL_SETUP,
    UL_A2,
    UL_B2
  } unlock_e;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_SETUP    = 8'h80;
  localparam logic [7:0] CMD_SECT     = 8'h30;
  localparam logic [7:0] CMD_SUSP     = 8'hB0;

endpackage

// File: rtl/seq_unlock.sv
module seq_unlock
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_A = 'h555,
  parameter logic [ADDR_W-1:0] ADDR_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              arm
);

  unlock_e step_q, step_d;
  logic hit_a, hit_b;

  assign hit_a = (wr_addr == ADDR_A);
  assign hit_b = (wr_addr == ADDR_B);

  always_comb begin
    step_d = step_q;
    if (!en) begin
      step_d = UL_IDLE;
    end else if (wr_valid) begin
      case (step_q)
        UL_IDLE:  step_d = (hit_a && wr_data == CMD_UNLOCK_A) ? UL_A1    : UL_IDLE;
        UL_A1:    step_d = (hit_b && wr_data == CMD_UNLOCK_B) ? UL_B1    : UL_IDLE;
        UL_B1:    step_d = (hit_a && wr_data == CMD_SETUP)    ? UL_SETUP : UL_IDLE;
        UL_SETUP: step_d = (hit_a && wr_data == CMD_UNLOCK_A) ? UL_A2    : UL_IDLE;
        UL_A2:    step_d = (hit_b && wr_data == CMD_UNLOCK_B) ? UL_B2    : UL_IDLE;
        default:  step_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= UL_IDLE;
    else        step_q <= step_d;
  end

  assign arm = en && wr_valid && (step_q == UL_B2) && (wr_data == CMD_SECT);

  // R9
  unlock_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> step_q == UL_IDLE);

  // R3
  unlock_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_valid && step_q == UL_A1 && !(hit_b && wr_data == CMD_UNLOCK_B))
    |=> step_q == UL_IDLE);

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);

  // R10
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt_q));

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/sector_queue.sv
module sector_queue #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [SECT_W-1:0]   set_idx,
  input  logic                clr,
  output logic [NUM_SECT-1:0] map
);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      map[g] <= 1'b0;
      else if (clr)                                    map[g] <= 1'b0;
      else if (set_en && set_idx == SECT_W'(g))        map[g] <= 1'b1;
    end
  end

  // R4
  queue_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |=> map[$past(set_idx)]);

  // R8
  queue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> map == '0);

endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SECT  = 8,
  parameter int WIN_CYC   = 6250,
  parameter int ERASE_CYC = 125000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic                ready_o,
  output logic                win_done_o,
  output logic                susp_o,
  output logic [NUM_SECT-1:0] pend_map_o
);

  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int CNT_MAX = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_e phase_q, phase_d;
  logic arm, t_clr, t_en, t_hit, q_set, q_clr;
  logic [CNT_W-1:0]  t_limit;
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

  seq_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .en(phase_q == PH_READ),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .arm(arm)
  );

  assign t_limit = (phase_q == PH_WINDOW) ? CNT_W'(WIN_CYC - 1) : CNT_W'(ERASE_CYC - 1);

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .en(t_en), .limit(t_limit), .hit(t_hit)
  );

  sector_queue #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .set_en(q_set), .set_idx(sect_idx),
    .clr(q_clr), .map(pend_map_o)
  );

  always_comb begin
    phase_d = phase_q;
    t_clr   = 1'b0;
    t_en    = 1'b0;
    q_set   = 1'b0;
    q_clr   = 1'b0;
    case (phase_q)
      PH_READ: begin
        if (arm) begin
          phase_d = PH_WINDOW;
          t_clr   = 1'b1;
          q_set   = 1'b1;
        end
      end
      PH_WINDOW: begin
        if (wr_valid) begin
          if (wr_data == CMD_SECT) begin
            q_set = 1'b1;
            t_clr = 1'b1;
          end else if (wr_data == CMD_SUSP) begin
            phase_d = PH_SUSP;
            t_clr   = 1'b1;
          end else begin
            phase_d = PH_READ;
            q_clr   = 1'b1;
          end
        end else if (t_hit) begin
          phase_d = PH_ERASE;
          t_clr   = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      PH_ERASE: begin
        if (wr_valid && wr_data == CMD_SUSP) begin
          phase_d = PH_SUSP;
        end else if (t_hit) begin
          phase_d = PH_READ;
          q_clr   = 1'b1;
          t_clr   = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      PH_SUSP: begin
        if (wr_valid && wr_data == CMD_SECT) phase_d = PH_ERASE;
      end
      default: phase_d = PH_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_READ;
    else        phase_q <= phase_d;
  end

  assign ready_o    = (phase_q == PH_READ) || (phase_q == PH_SUSP);
  assign win_done_o = (phase_q == PH_ERASE) || (phase_q == PH_SUSP);
  assign susp_o     = (phase_q == PH_SUSP);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!ready_o && !win_done_o && pend_map_o != '0));

  // R6
  window_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WINDOW && wr_valid && wr_data != CMD_SECT && wr_data != CMD_SUSP)
    |=> (ready_o && !win_done_o && pend_map_o == '0));

  // R9
  erase_map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ERASE) |=> ($stable(pend_map_o) || pend_map_o == '0));

  // R12
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SUSP && !(wr_valid && wr_data == CMD_SECT))
    |=> (susp_o && $stable(pend_map_o)));

  // R7
  window_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WINDOW && wr_valid && wr_data == CMD_SUSP) |=> (susp_o && ready_o));

endmodule

// File: tb/erase_cmd_seq_test.sv
module erase_cmd_seq_test;

  localparam int AW  = 12;
  localparam int NS  = 8;
  localparam int WIN = 6;
  localparam int ER  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ready_o, win_done_o, susp_o;
  logic [NS-1:0] pend_map_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model: phase 0 read, 1 window, 2 erase, 3 suspended
  int m_ph = 0, m_step = 0, m_cnt = 0;
  logic [NS-1:0] m_map = '0;

  always #4 clk = ~clk;

  erase_cmd_seq #(.ADDR_W(AW), .NUM_SECT(NS), .WIN_CYC(WIN), .ERASE_CYC(ER)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready_o(ready_o), .win_done_o(win_done_o), .susp_o(susp_o), .pend_map_o(pend_map_o)
  );

  function automatic logic [10:0] got();
    return {ready_o, win_done_o, susp_o, pend_map_o};
  endfunction

  function automatic logic [10:0] want();
    return {(m_ph == 0 || m_ph == 3), (m_ph >= 2), (m_ph == 3), m_map};
  endfunction

  function automatic string ph_tag();
    case (m_ph)
      0: return "R3";
      1: return "R4";
      2: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_step = 0; m_cnt = 0; m_map = '0;
  endtask

  task automatic model_step(logic v, logic [AW-1:0] a, logic [7:0] d);
    int sec = int'(a[AW-1 -: 3]);
    case (m_ph)
      0: if (v) begin
        case (m_step)
          0: m_step = (a == 12'h555 && d == 8'hAA) ? 1 : 0;
          1: m_step = (a == 12'h2AA && d == 8'h55) ? 2 : 0;
          2: m_step = (a == 12'h555 && d == 8'h80) ? 3 : 0;
          3: m_step = (a == 12'h555 && d == 8'hAA) ? 4 : 0;
          4: m_step = (a == 12'h2AA && d == 8'h55) ? 5 : 0;
          default: begin
            if (d == 8'h30) begin m_ph = 1; m_cnt = 0; m_map[sec] = 1'b1; end
            m_step = 0;
          end
        endcase
      end
      1: if (v) begin
        if (d == 8'h30) begin m_map[sec] = 1'b1; m_cnt = 0; end
        else if (d == 8'hB0) begin m_ph = 3; m_cnt = 0; end
        else begin m_ph = 0; m_map = '0; end
      end else if (m_cnt == WIN - 1) begin m_ph = 2; m_cnt = 0; end
      else m_cnt++;
      2: if (v && d == 8'hB0) m_ph = 3;
      else if (m_cnt == ER - 1) begin m_ph = 0; m_map = '0; m_cnt = 0; end
      else m_cnt++;
      default: if (v && d == 8'h30) m_ph = 2;
    endcase
  endtask

  task automatic cyc(logic v, logic [AW-1:0] a, logic [7:0] d, string tag);
    wr_valid = v; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    model_step(v, a, d);
    @(negedge clk);
    check(tag, got(), want());
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 8'h00, tag);
  endtask

  task automatic seq(int sect, int bad_step, string tag);
    logic [AW-1:0] ad [6];
    logic [7:0] dt [6];
    ad = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, {sect[2:0], 9'h0}};
    dt = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    for (int i = 0; i < 6; i++)
      cyc(1'b1, ad[i], (i == bad_step) ? (dt[i] ^ 8'h01) : dt[i], tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EC7_0123);
    @(negedge clk);
    check("R1", got(), 11'b100_00000000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", got(), 11'b100_00000000);

    // R2 + R4 + R5 + R9 + R8
    seq(2, -1, "R2");
    check("R2", got(), 11'b000_00000100);
    idle(WIN - 1, "R4");
    cyc(1'b1, {3'd5, 9'h011}, 8'h30, "R4");
    cyc(1'b1, {3'd7, 9'h0F0}, 8'h30, "R4");
    check("R4", got(), 11'b000_10100100);
    idle(WIN - 1, "R5");
    check("R5", got(), 11'b000_10100100);
    idle(1, "R5");
    check("R5", got(), 11'b010_10100100);
    seq(0, -1, "R9");
    cyc(1'b1, 12'h000, 8'h80, "R9");
    check("R9", got(), 11'b010_10100100);
    idle(ER - 8, "R8");
    check("R8", got(), 11'b010_10100100);
    idle(1, "R8");
    check("R8", got(), 11'b100_00000000);

    // R3 corrupted steps
    for (int b = 0; b < 6; b++) begin
      seq(3, b, "R3");
      check("R3", got(), 11'b100_00000000);
    end

    // R6 abort
    seq(4, -1, "R6");
    idle(2, "R6");
    cyc(1'b1, 12'h555, 8'hF0, "R6");
    check("R6", got(), 11'b100_00000000);

    // R7 suspend in window, R12 ignored writes, R10 full erase after resume
    seq(1, -1, "R7");
    cyc(1'b1, 12'h000, 8'hB0, "R7");
    check("R7", got(), 11'b111_00000010);
    cyc(1'b1, 12'h555, 8'hAA, "R12");
    cyc(1'b1, 12'h2AA, 8'h80, "R12");
    idle(3, "R12");
    check("R12", got(), 11'b111_00000010);
    cyc(1'b1, 12'h000, 8'h30, "R10");
    idle(ER - 1, "R10");
    check("R10", got(), 11'b010_00000010);
    idle(1, "R10");
    check("R10", got(), 11'b100_00000000);

    // R10 suspend during erase keeps elapsed count
    seq(6, -1, "R10");
    idle(WIN, "R10");
    idle(3, "R10");
    cyc(1'b1, 12'h123, 8'hB0, "R10");
    idle(4, "R12");
    check("R12", got(), 11'b111_01000000);
    cyc(1'b1, 12'h000, 8'h30, "R10");
    idle(6, "R10");
    check("R10", got(), 11'b010_01000000);
    idle(1, "R10");
    check("R10", got(), 11'b100_00000000);

    // R11 reset during erase
    seq(5, -1, "R11");
    idle(WIN + 2, "R11");
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R11", got(), 11'b100_00000000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11", got(), 11'b100_00000000);

    // constrained random episodes
    for (int ep = 0; ep < 300; ep++) begin
      int bad = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 5)) : -1;
      int nact = int'($urandom_range(0, 8));
      int guard = 0;
      seq(int'($urandom_range(0, 7)), bad, ph_tag());
      for (int k = 0; k < nact; k++) begin
        int pick = int'($urandom_range(0, 99));
        idle(int'($urandom_range(0, WIN + 1)), ph_tag());
        if (pick < 60)
          cyc(1'b1, {$urandom_range(0, 7)}[2:0] << 9, 8'h30, ph_tag());
        else if (pick < 75)
          cyc(1'b1, 12'(($urandom_range(0, 4095))), 8'hB0, ph_tag());
        else
          cyc(1'b1, 12'($urandom_range(0, 4095)), 8'($urandom_range(0, 255)), ph_tag());
      end
      while (m_ph != 0 && guard < 4 * (WIN + ER)) begin
        if (m_ph == 3) cyc(1'b1, 12'h000, 8'h30, "R10");
        else idle(1, ph_tag());
        guard++;
      end
    end

    finish_run();
  end

endmodule